// File: doc/BRIEF.md
# GPIO State Text Line Transmitter

This block turns the two 32-bit GPIO state words, the output-enable word and the output-data word, into short printable text lines. It feeds those lines one byte at a time into a byte-stream sink with a valid/ready handshake, such as the input of a serial transmitter. A register block or a command parser raises a one-cycle request with the current words. The request also says whether the output-enable word changed. The block picks the lines to send from that flag.

Each line is a fixed-width record: a tag letter, a colon, eight lowercase hexadecimal digits, then carriage return and line feed. The words are captured when a request arrives. Requests that arrive while a message is going out are merged into one pending message, which carries the most recent words. Nothing is sent while the link is down. When the link comes up, the block sends its full state and then a query line.

Top module: `gpio_line_tx`

## Requirements
- R1: Every record is exactly 12 bytes: a tag byte, `:` (0x3A), eight hex digits of the 32-bit word with the most significant nibble first, using `0`-`9` and lowercase `a`-`f`, then 0x0D and 0x0A.
- R2: The output-enable record is tagged `D` (0x44), the output-data record `O` (0x4F) and the query record `Q` (0x51). The query record carries the output-enable word.
- R3: A request with `req_with_oe`=1 produces a `D` record followed by an `O` record. A request with `req_with_oe`=0 produces only an `O` record.
- R4: After reset, the block holds a pending `D` then `O` message carrying all-zero words, and sends it once the link is connected.
- R5: A rise of `link_up` queues a message of `D`, `O`, then `Q`. Reset clears the remembered link level, so a link that is already high after reset counts as newly connected. Any pending message merges into this one.
- R6: While `link_up` is low, `tx_valid` is low. A message cut by a link drop resumes at the same byte once the link returns.
- R7: Words are captured on `req_valid`. Requests that arrive during a message collapse into one pending message with the latest words. That message includes `D` if any of the merged requests asked for it.
- R8: A byte advances only on a cycle with `tx_valid` and `tx_ready` both high. While stalled, `tx_data` holds its value.
- R9: A synchronous active-high `rst` returns the block to idle with `tx_valid` low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Byte-stream link is connected |
| req_valid | input | 1 | One-cycle request strobe |
| req_with_oe | input | 1 | Request includes the output-enable record |
| oe_word | input | 32 | Output-enable word, sampled on req_valid |
| out_word | input | 32 | Output-data word, sampled on req_valid |
| tx_data | output | 8 | Byte offered to the sink |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
A wrong byte index or record kind shows at the ports on the very next accepted byte: a misplaced colon, a missing CR or LF, or a digit in the wrong nibble position. A lost or stale pending flag shows later. After the current message ends, the sink sees a missing `D` record, an extra message, or words older than the latest request. The scoreboard compares every accepted byte against lines built in the bench from the requested words. This places the first wrong byte at the exact handshake where it occurs.

// File: rtl/gpio_line_pkg.sv
package gpio_line_pkg;

    localparam int WORD_W  = 32;
    localparam int NIBBLES = WORD_W / 4;
    localparam int REC_LEN = NIBBLES + 4;
    localparam int IDX_W   = $clog2(REC_LEN);

    typedef enum logic [1:0] {
        REC_OE  = 2'd0,
        REC_OUT = 2'd1,
        REC_QRY = 2'd2
    } rec_kind_t;

    typedef struct packed {
        logic valid;
        logic with_oe;
        logic with_qry;
    } pend_t;

    typedef struct packed {
        logic [WORD_W-1:0] oe;
        logic [WORD_W-1:0] out;
    } words_t;

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'b0, n};
        else           return 8'h57 + {4'b0, n};
    endfunction

    function automatic logic [7:0] tag_char(input rec_kind_t k);
        case (k)
            REC_OE:  return 8'h44;
            REC_OUT: return 8'h4F;
            default: return 8'h51;
        endcase
    endfunction

    function automatic logic [7:0] rec_byte(input rec_kind_t k,
                                            input logic [WORD_W-1:0] w,
                                            input logic [IDX_W-1:0] idx);
        int unsigned        i;
        int unsigned        sh;
        logic [WORD_W-1:0]  t;
        i = int'(idx);
        if (i == 0)                return tag_char(k);
        else if (i == 1)           return 8'h3A;
        else if (i == REC_LEN - 2) return 8'h0D;
        else if (i == REC_LEN - 1) return 8'h0A;
        else begin
            sh = 4 * (NIBBLES + 1 - i);
            t  = w >> sh;
            return hex_char(t[3:0]);
        end
    endfunction

endpackage

// File: rtl/gpio_line_req.sv
module gpio_line_req
    import gpio_line_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              req_valid,
    input  logic              req_with_oe,
    input  logic [WORD_W-1:0] oe_word,
    input  logic [WORD_W-1:0] out_word,
    input  logic              take,
    output words_t            shadow,
    output pend_t             pend,
    output logic              link_stable
);

    logic  link_q;
    logic  link_rise;
    pend_t base;

    assign link_rise   = link_up & ~link_q;
    assign link_stable = link_up & link_q;
    assign base        = take ? '0 : pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= 1'b0;
            shadow <= '0;
            pend   <= '{valid: 1'b1, with_oe: 1'b1, with_qry: 1'b0};
        end else begin
            link_q        <= link_up;
            pend.valid    <= base.valid | req_valid | link_rise;
            pend.with_oe  <= base.with_oe | (req_valid & req_with_oe) | link_rise;
            pend.with_qry <= base.with_qry | link_rise;
            if (req_valid) begin
                shadow.oe  <= oe_word;
                shadow.out <= out_word;
            end
        end
    end

endmodule

// File: rtl/gpio_line_seq.sv
module gpio_line_seq
    import gpio_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       link_up,
    input  logic       start,
    input  pend_t      pend,
    input  words_t     shadow,
    input  logic       tx_ready,
    output logic       busy,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    rec_kind_t          kind;
    logic [IDX_W-1:0]   idx;
    logic               qry_due;
    words_t             act;
    logic               fire;
    logic               last;
    logic [WORD_W-1:0]  word_sel;

    assign tx_valid = busy & link_up;
    assign fire     = tx_valid & tx_ready;
    assign last     = (idx == IDX_W'(REC_LEN - 1));
    assign word_sel = (kind == REC_OUT) ? act.out : act.oe;
    assign tx_data  = rec_byte(kind, word_sel, idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            kind    <= REC_OUT;
            idx     <= '0;
            qry_due <= 1'b0;
            act     <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            kind    <= pend.with_oe ? REC_OE : REC_OUT;
            idx     <= '0;
            qry_due <= pend.with_qry;
            act     <= shadow;
        end else if (fire) begin
            if (last) begin
                idx <= '0;
                case (kind)
                    REC_OE:  kind <= REC_OUT;
                    REC_OUT: begin
                        if (qry_due) kind <= REC_QRY;
                        else         busy <= 1'b0;
                    end
                    default: busy <= 1'b0;
                endcase
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_line_tx.sv
module gpio_line_tx
    import gpio_line_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              req_valid,
    input  logic              req_with_oe,
    input  logic [WORD_W-1:0] oe_word,
    input  logic [WORD_W-1:0] out_word,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready
);

    words_t shadow;
    pend_t  pend;
    logic   link_stable;
    logic   busy;
    logic   start;

    assign start = ~busy & pend.valid & link_stable;

    gpio_line_req u_req (
        .clk         (clk),
        .rst         (rst),
        .link_up     (link_up),
        .req_valid   (req_valid),
        .req_with_oe (req_with_oe),
        .oe_word     (oe_word),
        .out_word    (out_word),
        .take        (start),
        .shadow      (shadow),
        .pend        (pend),
        .link_stable (link_stable)
    );

    gpio_line_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .link_up  (link_up),
        .start    (start),
        .pend     (pend),
        .shadow   (shadow),
        .tx_ready (tx_ready),
        .busy     (busy),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

endmodule

// File: rtl/gpio_line_tx_chk.sv
module gpio_line_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       link_up,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data
);

    assert_quiet_link_R6: assert property (@(posedge clk) disable iff (rst)
        !link_up |-> !tx_valid);

    assert_stall_data_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> $stable(tx_data));

    assert_stall_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid || !link_up));

    assert_cr_then_lf_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_data == 8'h0D) |=> (tx_data == 8'h0A));

    assert_tag_then_colon_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready &&
         (tx_data == 8'h44 || tx_data == 8'h4F || tx_data == 8'h51))
        |=> (tx_data == 8'h3A));

    assert_idle_after_reset_R9: assert property (@(posedge clk)
        $past(rst) |-> !tx_valid);

endmodule

bind gpio_line_tx gpio_line_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .link_up  (link_up),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
);

// File: tb/gpio_line_tx_bench.sv
module gpio_line_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_with_oe = 1'b0;
    logic [31:0] oe_word = '0;
    logic [31:0] out_word = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic ready_all = 1'b1;

    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [31:0] m_oe = '0;
    logic [31:0] m_out = '0;

    always #2 clk = ~clk;

    gpio_line_tx u_gpio_line_tx (
        .clk         (clk),
        .rst         (rst),
        .link_up     (link_up),
        .req_valid   (req_valid),
        .req_with_oe (req_with_oe),
        .oe_word     (oe_word),
        .out_word    (out_word),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready)
    );

    task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push_rec(input logic [7:0] tag, input logic [31:0] w, input string rq);
        string s;
        s = $sformatf("%c:%08h", tag, w);
        for (int i = 0; i < s.len(); i++) begin
            exp_q.push_back(s[i]);
            req_q.push_back(rq);
        end
        exp_q.push_back(8'h0D); req_q.push_back(rq);
        exp_q.push_back(8'h0A); req_q.push_back(rq);
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_req(input logic with_oe, input logic [31:0] oe, input logic [31:0] out);
        req_valid   = 1'b1;
        req_with_oe = with_oe;
        oe_word     = oe;
        out_word    = out;
        m_oe        = oe;
        m_out       = out;
        tick();
        req_valid   = 1'b0;
    endtask

    task automatic request(input logic with_oe, input logic [31:0] oe, input logic [31:0] out);
        pulse_req(with_oe, oe, out);
        if (with_oe) push_rec(8'h44, oe, "R3");
        push_rec(8'h4F, out, "R3");
    endtask

    task automatic drain;
        while (exp_q.size() != 0) tick();
        repeat (4) tick();
        check(tx_valid == 1'b0, "R3 no extra bytes", 32'(tx_valid), 0);
    endtask

    // ready pattern
    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = ready_all ? 1'b1 : ((cyc % 4) != 1);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected byte", 32'(tx_data), 0);
            end else begin
                logic [7:0] e;
                string      r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(tx_data == e, {r, " R1 byte"}, 32'(tx_data), 32'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        check(tx_valid == 1'b0, "R9 reset idle", 32'(tx_valid), 0);

        // link down: nothing sent, reset message held (R6, R4)
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(tx_valid == 1'b0, "R6 link down quiet", 32'(tx_valid), 0);
        end
        tick();
        link_up = 1'b1;
        push_rec(8'h44, 32'h0, "R4");
        push_rec(8'h4F, 32'h0, "R4");
        push_rec(8'h51, 32'h0, "R5");
        drain();

        // single requests (R3, R1, R2)
        request(1'b0, 32'h1111_2222, 32'h89ab_cdef);
        drain();
        request(1'b1, 32'h0123_abcd, 32'hfedc_9876);
        drain();

        // backpressure (R8)
        ready_all = 1'b0;
        request(1'b1, 32'hffff_ffff, 32'h0000_0000);
        drain();
        request(1'b0, 32'h5a5a_5a5a, 32'ha0b1_c2d3);
        drain();

        // coalescing while busy (R7)
        request(1'b1, 32'h1234_5678, 32'h9abc_def0);
        while (!tx_valid) tick();
        pulse_req(1'b1, 32'hdead_0001, 32'hbeef_0001);
        pulse_req(1'b0, 32'h0f0f_f0f0, 32'h3c3c_c3c3);
        push_rec(8'h44, 32'h0f0f_f0f0, "R7");
        push_rec(8'h4F, 32'h3c3c_c3c3, "R7");
        drain();

        // link drop mid-message, then reconnect (R6, R5)
        ready_all = 1'b1;
        request(1'b1, 32'h7654_3210, 32'h0246_8ace);
        while (exp_q.size() > 18) tick();
        link_up = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(tx_valid == 1'b0, "R6 dropped link quiet", 32'(tx_valid), 0);
            tick();
        end
        link_up = 1'b1;
        push_rec(8'h44, m_oe, "R5");
        push_rec(8'h4F, m_out, "R5");
        push_rec(8'h51, m_oe, "R5");
        drain();

        // reset with link held high (R9, R4, R5)
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        m_oe = '0;
        m_out = '0;
        @(negedge clk);
        check(tx_valid == 1'b0, "R9 idle after reset", 32'(tx_valid), 0);
        push_rec(8'h44, 32'h0, "R4");
        push_rec(8'h4F, 32'h0, "R4");
        push_rec(8'h51, 32'h0, "R5");
        drain();

        check(exp_q.size() == 0, "R3 queue empty", 32'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule